// File: doc/BRIEF.md
# Multiplexed BCD digit scanner

This block sits after the count latches of a dual-slope converter. It presents a five-digit BCD reading one digit at a time on a shared 4-bit bus, with a one-hot digit-select bus that walks from the most significant digit down to the least and then starts again. Each time a new measurement completes, it sends one short active-low strobe per digit, placed in the middle of the digit slot. External latches or a host can capture the BCD value on that strobe without racing the bus. When the reading is over-range, the selects go dark after the strobe burst and stay dark until the sequencer enters its next reference-integrate phase. This makes the display blink.

The block is clocked at twice the count rate. Every second clock edge after reset is a count edge, and all slot timing below is in counts. A strobe lasts one clock, which is half a count. The wide mode gives slots of `SLOT_FULL` counts (200 by default, the 4.5-digit case). The narrow mode gives slots of `SLOT_SHORT` counts (20 by default, the 3.5-digit case). The end-of-measurement and reference-start pulses may be one or two clocks wide. Each is acted on at the first count edge that falls during the pulse or after it.

Top module: `bcd_digit_scanner`

## Requirements
- R1: While reset is asserted, the most significant digit select (bit 4) is active, the other selects are low, and `strobeN` is high.
- R2: The digit selects are one-hot and advance in the order bit 4, 3, 2, 1, 0, then back to bit 4, repeating without end.
- R3: Each ordinary slot lasts `SLOT_FULL` counts when `wideMode` is 1 and `SLOT_SHORT` counts when it is 0. All five selects take part in the scan in both modes.
- R4: At the count edge that takes an end-of-measurement pulse, the scan restarts at bit 4. That first slot is one count longer than an ordinary slot.
- R5: Each measurement yields exactly five strobes. The first falls in count N/2+1 after the restart, where N is the slot length. Each later strobe falls in count N/2 of the next digit's slot.
- R6: A strobe holds `strobeN` low for one clock, the second half of its count. The digit selects do not change while it is low.
- R7: `bcdOut` carries the field of the selected digit, positive logic. Bit 4's digit is `digitsIn[19:16]` and bit 0's digit is `digitsIn[3:0]`. It changes on the same edge as the selects.
- R8: If `overRange` was high when the measurement was taken, all selects go low from the count after the fifth strobe. They stay low until a reference-start pulse. The scan then resumes at bit 4 with an ordinary-length slot and no strobes.
- R9: A reference-start pulse while the selects are not blanked has no effect on the scan.
- R10: After the fifth strobe the scan keeps running, but `strobeN` stays high until the next end-of-measurement pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the count rate |
| rstN | input | 1 | Asynchronous reset, active low |
| wideMode | input | 1 | 1 selects long slots, 0 selects short slots |
| digitsIn | input | 20 | Latched reading, most significant digit in the top nibble |
| overRange | input | 1 | Reading exceeds range; sampled with the end-of-measurement pulse |
| measEnd | input | 1 | End-of-measurement pulse from the sequencer |
| refStart | input | 1 | Start-of-reference-integrate pulse from the sequencer |
| digitSel | output | 5 | One-hot digit select, bit 4 is the most significant digit |
| bcdOut | output | 4 | BCD value of the selected digit |
| strobeN | output | 1 | Active-low data strobe, one clock wide |

## Verification
The bench builds the scanner with slots of 8 counts (wide) and 4 counts (narrow). At these sizes a single window covers a full strobe burst, the scan wrap, the long first slot, the blanking interval and the restart after a reference pulse, and every half-count is compared. Expected selects, BCD values and strobe positions come from closed-form slot arithmetic in counts since the end-of-measurement edge. The windows cover both modes, over-range with and without blanking, and a reference pulse that must be ignored.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Control-to-datapath strobes, all qualified to count edges.
  typedef struct packed {
    logic restart;  // jump to the most significant digit
    logic advance;  // step to the next digit
    logic blank;    // force all selects low
  } scanCtl_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int SLOT_FULL  = 200,
  parameter int SLOT_SHORT = 20,
  parameter int DIGITS     = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wideMode,
  input  logic     overRange,
  input  logic     measEnd,
  input  logic     refStart,
  output scanCtl_t ctl,
  output logic     strobeN
);
  localparam int CW = $clog2(SLOT_FULL + 2);
  localparam int PW = $clog2(DIGITS + 1);

  logic          phase;
  logic          measReq, refReq;
  logic [CW-1:0] slotCnt;
  logic          longSlot;
  logic [PW-1:0] pending;
  logic          ovrHeld;
  logic          blankR;

  logic [CW-1:0] slotLen, slotEnd, strobePos;
  logic          measGo, refGo, slotLast, hit;

  always_comb begin
    slotLen   = wideMode ? CW'(SLOT_FULL) : CW'(SLOT_SHORT);
    slotEnd   = slotLen - CW'(1) + CW'(longSlot);
    strobePos = (slotLen >> 1) + CW'(longSlot);
    measGo    = phase && (measEnd || measReq);
    refGo     = phase && (refStart || refReq) && blankR && !measGo;
    slotLast  = (slotCnt == slotEnd);
    hit       = (pending != '0) && (slotCnt == strobePos);
    ctl.restart = measGo || refGo;
    ctl.advance = phase && !measGo && !refGo && slotLast;
    ctl.blank   = blankR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= 1'b0;
      measReq  <= 1'b0;
      refReq   <= 1'b0;
      slotCnt  <= '0;
      longSlot <= 1'b0;
      pending  <= '0;
      ovrHeld  <= 1'b0;
      blankR   <= 1'b0;
      strobeN  <= 1'b1;
    end else begin
      phase   <= ~phase;
      strobeN <= !(!phase && hit);
      if (!phase) begin
        measReq <= measReq | measEnd;
        refReq  <= refReq | refStart;
      end else begin
        measReq <= 1'b0;
        refReq  <= 1'b0;
        if (measGo) begin
          slotCnt  <= '0;
          longSlot <= 1'b1;
          pending  <= PW'(DIGITS);
          ovrHeld  <= overRange;
          blankR   <= 1'b0;
        end else if (refGo) begin
          slotCnt  <= '0;
          longSlot <= 1'b0;
          blankR   <= 1'b0;
        end else begin
          if (hit) begin
            pending <= pending - PW'(1);
            if (pending == PW'(1) && ovrHeld) blankR <= 1'b1;
          end
          if (slotLast) begin
            slotCnt  <= '0;
            longSlot <= 1'b0;
          end else begin
            slotCnt <= slotCnt + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int DIGITS = 5,
  parameter int BCD_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  scanCtl_t                ctl,
  input  logic [DIGITS*BCD_W-1:0] digitsIn,
  output logic [DIGITS-1:0]       digitSel,
  output logic [BCD_W-1:0]        bcdOut
);
  localparam int IW    = $clog2(DIGITS);
  localparam int SLOTS = 1 << IW;

  logic [IW-1:0]    idx;
  logic [BCD_W-1:0] field [SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idx <= '0;
    else if (ctl.restart) idx <= '0;
    else if (ctl.advance) idx <= (idx == IW'(DIGITS - 1)) ? '0 : idx + IW'(1);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_field
    if (g < DIGITS) begin : g_live
      assign field[g] = digitsIn[(DIGITS-1-g)*BCD_W +: BCD_W];
      assign digitSel[DIGITS-1-g] = !ctl.blank && (idx == IW'(g));
    end else begin : g_pad
      assign field[g] = '0;
    end
  end

  assign bcdOut = field[idx];
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
  import scan_pkg::*;
#(
  parameter int SLOT_FULL  = 200,
  parameter int SLOT_SHORT = 20,
  parameter int DIGITS     = 5,
  parameter int BCD_W      = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wideMode,
  input  logic [DIGITS*BCD_W-1:0] digitsIn,
  input  logic                    overRange,
  input  logic                    measEnd,
  input  logic                    refStart,
  output logic [DIGITS-1:0]       digitSel,
  output logic [BCD_W-1:0]        bcdOut,
  output logic                    strobeN
);
  scanCtl_t ctl;

  scan_ctrl #(.SLOT_FULL(SLOT_FULL), .SLOT_SHORT(SLOT_SHORT), .DIGITS(DIGITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .overRange(overRange),
    .measEnd(measEnd), .refStart(refStart), .ctl(ctl), .strobeN(strobeN)
  );

  scan_datapath #(.DIGITS(DIGITS), .BCD_W(BCD_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .digitsIn(digitsIn),
    .digitSel(digitSel), .bcdOut(bcdOut)
  );
endmodule

// File: rtl/bcd_digit_scanner_chk.sv
module bcd_digit_scanner_chk #(
  parameter int DIGITS = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [DIGITS-1:0] digitSel,
  input logic              strobeN
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(digitSel));

  p_strobe_one_clock_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |=> strobeN);

  p_select_still_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |-> $stable(digitSel));

  p_no_strobe_dark_r8: assert property (@(posedge clk) disable iff (!rstN)
    (digitSel == '0) |-> strobeN);
endmodule

bind bcd_digit_scanner bcd_digit_scanner_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rstN(rstN), .digitSel(digitSel), .strobeN(strobeN)
);

// File: tb/bcd_digit_scanner_tb.sv
module bcd_digit_scanner_tb;
  localparam int NF = 8;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wideMode = 1'b1;
  logic [19:0] digitsIn = 20'h12345;
  logic        overRange = 1'b0;
  logic        measEnd = 1'b0;
  logic        refStart = 1'b0;
  logic [4:0]  digitSel;
  logic [3:0]  bcdOut;
  logic        strobeN;

  int checks = 0;
  int failures = 0;
  int edgeCnt;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_digit_scanner #(.SLOT_FULL(NF), .SLOT_SHORT(NS)) u_dut (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .digitsIn(digitsIn),
    .overRange(overRange), .measEnd(measEnd), .refStart(refStart),
    .digitSel(digitSel), .bcdOut(bcdOut), .strobeN(strobeN)
  );

  always @(posedge clk or negedge rstN)
    if (!rstN) edgeCnt <= 0;
    else edgeCnt <= edgeCnt + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int strobeAt(input int n, input int j);
    return (j == 0) ? n/2 + 1 : n + 1 + (j-1)*n + n/2;
  endfunction

  function automatic bit isStrobe(input int n, input int k);
    for (int j = 0; j < 5; j++) if (strobeAt(n, j) == k) return 1'b1;
    return 1'b0;
  endfunction

  task automatic pulseMeas(input bit ovr);
    @(negedge clk);
    while (edgeCnt % 2 != 0) @(negedge clk);
    overRange = ovr;
    measEnd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    measEnd = 1'b0;
  endtask

  // Samples count k = 0..kEnd after the end-of-measurement edge.
  task automatic runWindow(input int n, input bit ovr, input int refAt,
                           input int kEnd, input string selTag);
    int s4 = strobeAt(n, 4);
    for (int k = 0; k <= kEnd; k++) begin
      int idx;
      bit dark;
      string tag;
      dark = ovr && k > s4 && (refAt < 0 || k <= refAt);
      if (ovr && refAt >= 0 && k > refAt) idx = ((k - refAt - 1) / n) % 5;
      else if (k <= n) idx = 0;
      else idx = ((k - n - 1) / n + 1) % 5;
      if (dark) tag = "R8";
      else if (ovr && refAt >= 0 && k > refAt) tag = "R8";
      else if (!ovr && refAt >= 0 && k > refAt) tag = "R9";
      else if (k <= n) tag = "R4";
      else tag = selTag;
      if (k == refAt) refStart = 1'b1;
      if (k == refAt + 1) refStart = 1'b0;
      chk(tag, digitSel, dark ? 0 : (5'b10000 >> idx));
      if (!dark) chk("R7", bcdOut, digitsIn[(4-idx)*4 +: 4]);
      chk("R6", strobeN, 1);
      @(negedge clk);
      chk(tag, digitSel, dark ? 0 : (5'b10000 >> idx));
      chk(k > s4 ? "R10" : "R5", strobeN, isStrobe(n, k) ? 0 : 1);
      @(negedge clk);
    end
    refStart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", digitSel, 5'b10000);
    chk("R1", strobeN, 1);
    chk("R1", bcdOut, 4'h1);
    rstN = 1'b1;

    wideMode = 1'b1; digitsIn = 20'h98765;
    pulseMeas(1'b0);
    runWindow(NF, 1'b0, -1, 7*NF + 1, "R2");

    wideMode = 1'b0; digitsIn = 20'h40213;
    pulseMeas(1'b0);
    runWindow(NS, 1'b0, -1, 7*NS + 1, "R3");

    wideMode = 1'b1; digitsIn = 20'h19999;
    pulseMeas(1'b1);
    runWindow(NF, 1'b1, 45, 46 + 3*NF, "R2");

    wideMode = 1'b0; digitsIn = 20'h05678;
    pulseMeas(1'b0);
    runWindow(NS, 1'b0, 10, 30, "R3");

    wideMode = 1'b0; digitsIn = 20'h1000f;
    pulseMeas(1'b1);
    runWindow(NS, 1'b1, 26, 27 + 2*NS, "R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule